// File: doc/BRIEF.md
# Formatted Surface Sample Packer

This block turns the source operands of a formatted surface store into the packed sample word that a memory write path puts into the surface. A store supplies one, two or four 32-bit elements, together with a description of the surface sample format: its data class (unsigned normalized, signed normalized, unsigned integer, signed integer or 32-bit float), its component width (8 or 16 bits for the non-float classes) and its channel count (one, two or four). The block reads each element as float, unsigned or signed according to the format class, not according to the store. It converts every component that the sample holds and the source supplies, places the results in R, G, B, A order and reports which bytes of the output word belong to the sample.

The block takes one request per cycle and has one register stage. The result word and byte-lane mask appear one cycle after the request and hold until the next request. Address generation and the memory write are left to the surrounding pipeline.

Top module: `sfc_store_packer`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low otherwise. After a synchronous reset `out_valid` is 0, and `out_data` and `out_lanes` are all zero.
- R2: Source element i (bits [32i+31:32i] of `in_src`) feeds component i, in the order R=0, G=1, B=2, A=3. Component i occupies bits [W*i+W-1:W*i] of `out_data`. W is 8 when `in_wide`=0, 16 when `in_wide`=1, and 32 for the float class whatever `in_wide` is.
- R3: `out_lanes` has its low (channels × W/8) bits set and all its other bits clear. Channels come from `in_chans`: 0 gives 1, 1 gives 2, 2 gives 4.
- R4: Source elements beyond the sample's channel count are discarded, and every output byte outside `out_lanes` is zero.
- R5: Components that the sample has but the source does not supply are written as zero. The supplied count comes from `in_count`: 0 gives 1, 1 gives 2, 2 gives 4.
- R6: Class 0 (unsigned normalized) reads the source as float32. It clamps to [0,1], scales by 2^W−1 and rounds to nearest even. NaN, negative values, zeros and denormals give 0. Values of 1.0 or more, including +inf, give all ones.
- R7: Class 1 (signed normalized) reads the source as float32. It clamps to [−1,1], scales by 2^(W−1)−1, rounds the magnitude to nearest even and writes two's complement. NaN gives 0.
- R8: Class 2 (unsigned integer) reads the source as unsigned 32-bit and saturates it to 2^W−1.
- R9: Class 3 (signed integer) reads the source as signed 32-bit and saturates it to [−2^(W−1), 2^(W−1)−1].
- R10: Class 4 (float) copies each 32-bit element unchanged, NaN payloads included.
- R11: A class code above 4, or a value of 3 in `in_chans` or `in_count`, makes the result all zero, with `out_lanes` zero; `out_valid` still pulses.
- R12: While `in_valid` is low, `out_data` and `out_lanes` keep their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_src | input | 128 | Four 32-bit source elements, element 0 in the low bits |
| in_class | input | 3 | Format class: 0 unorm, 1 snorm, 2 uint, 3 sint, 4 float |
| in_wide | input | 1 | Component width: 0 for 8 bits, 1 for 16 bits (ignored for float) |
| in_chans | input | 2 | Sample channel count code: 0/1/2 gives 1/2/4 |
| in_count | input | 2 | Source element count code: 0/1/2 gives 1/2/4 |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_data | output | 128 | Packed sample word, component R in the low bits |
| out_lanes | output | 16 | Byte-lane valid mask for `out_data` |

## Verification
Normalized conversions are tried with exact halves, so that round-to-nearest-even can be told apart from truncation and from rounding half up. They also get out-of-range values, infinities and NaN, which show whether clamping and NaN handling are done. Integer classes get values just inside and just outside each destination range, with both signs, so that saturation can be told apart from truncation to the low bits. Mismatched source and channel counts in both directions show whether extra elements are discarded and missing components are zero-filled. Float pass-through with a width bit that disagrees shows that the float class ignores that bit. Invalid codes and idle cycles with changing inputs check the all-zero and hold behaviour.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  localparam int ELEM_W   = 32;
  localparam int NCOMP    = 4;
  localparam int WORD_W   = ELEM_W * NCOMP;
  localparam int LANE_W   = WORD_W / 8;
  localparam int CNT_W    = $clog2(NCOMP + 1);
  localparam int BYTES_W  = $clog2(LANE_W + 1);

  typedef enum logic [2:0] {
    CLS_UNORM = 3'd0,
    CLS_SNORM = 3'd1,
    CLS_UINT  = 3'd2,
    CLS_SINT  = 3'd3,
    CLS_FLOAT = 3'd4
  } sfc_class_e;

  // Magnitude of a normal float below 1.0, scaled by maxv, rounded half to even.
  function automatic logic [15:0] scale_mag(input logic [7:0] ex, input logic [22:0] fr,
                                            input logic [15:0] maxv);
    logic [63:0] prod;
    logic [63:0] q;
    logic [63:0] rem;
    logic [63:0] half;
    int          sh;
    prod = 64'({1'b1, fr}) * 64'(maxv);
    sh   = 150 - int'(ex);
    if (sh >= 48) return 16'd0;
    q    = prod >> sh;
    rem  = prod & ((64'd1 << sh) - 64'd1);
    half = 64'd1 << (sh - 1);
    if ((rem > half) || ((rem == half) && q[0])) q = q + 64'd1;
    return q[15:0];
  endfunction

  function automatic logic [15:0] cvt_unorm(input logic [31:0] f, input int unsigned nb);
    logic [15:0] maxv;
    maxv = 16'((32'd1 << nb) - 32'd1);
    if (f[30:23] == 8'hFF && f[22:0] != 23'd0) return 16'd0;
    if (f[31] || f[30:23] == 8'd0) return 16'd0;
    if (f[30:23] >= 8'd127) return maxv;
    return scale_mag(f[30:23], f[22:0], maxv);
  endfunction

  function automatic logic [15:0] cvt_snorm(input logic [31:0] f, input int unsigned nb);
    logic [15:0] maxv;
    logic [15:0] mag;
    maxv = 16'((32'd1 << (nb - 1)) - 32'd1);
    if (f[30:23] == 8'hFF && f[22:0] != 23'd0) return 16'd0;
    if (f[30:23] == 8'd0) return 16'd0;
    if (f[30:23] >= 8'd127) mag = maxv;
    else                    mag = scale_mag(f[30:23], f[22:0], maxv);
    return f[31] ? (16'd0 - mag) : mag;
  endfunction

  function automatic logic [15:0] sat_uint(input logic [31:0] v, input int unsigned nb);
    logic [31:0] maxv;
    maxv = (32'd1 << nb) - 32'd1;
    return (v > maxv) ? maxv[15:0] : v[15:0];
  endfunction

  function automatic logic [15:0] sat_sint(input logic [31:0] v, input int unsigned nb);
    logic signed [31:0] s;
    logic signed [31:0] hi;
    logic signed [31:0] lo;
    s  = signed'(v);
    hi = signed'((32'd1 << (nb - 1)) - 32'd1);
    lo = -hi - 32'sd1;
    if (s > hi) return hi[15:0];
    if (s < lo) return lo[15:0];
    return s[15:0];
  endfunction

endpackage

// File: rtl/sfc_decode.sv
module sfc_decode
  import sfc_pkg::*;
(
  input  logic [2:0]         cls_raw,
  input  logic               wide,
  input  logic [1:0]         chan_code,
  input  logic [1:0]         cnt_code,
  output sfc_class_e         cls,
  output logic [2:0]         wsel,
  output logic [CNT_W-1:0]   nchan,
  output logic [CNT_W-1:0]   nsrc,
  output logic [BYTES_W-1:0] nbytes
);

  logic ok;

  function automatic logic [CNT_W-1:0] code_to_n(input logic [1:0] c);
    case (c)
      2'd0:    return CNT_W'(1);
      2'd1:    return CNT_W'(2);
      2'd2:    return CNT_W'(4);
      default: return '0;
    endcase
  endfunction

  always_comb begin
    ok    = (cls_raw <= 3'd4) && (chan_code != 2'd3) && (cnt_code != 2'd3);
    cls   = ok ? sfc_class_e'(cls_raw) : CLS_UINT;
    nchan = ok ? code_to_n(chan_code) : '0;
    nsrc  = ok ? code_to_n(cnt_code) : '0;
    if (cls == CLS_FLOAT) wsel = 3'b100;
    else if (wide)        wsel = 3'b010;
    else                  wsel = 3'b001;
    case (wsel)
      3'b100:  nbytes = BYTES_W'(nchan) << 2;
      3'b010:  nbytes = BYTES_W'(nchan) << 1;
      default: nbytes = BYTES_W'(nchan);
    endcase
  end

  always_comb begin
    p_width_onehot_r2: assert ($onehot(wsel));
    if (!ok) p_bad_code_r11: assert (nchan == '0 && nbytes == '0);
  end

endmodule

// File: rtl/sfc_lane_conv.sv
module sfc_lane_conv
  import sfc_pkg::*;
(
  input  logic [ELEM_W-1:0] src,
  input  sfc_class_e        cls,
  output logic [7:0]        c8,
  output logic [15:0]       c16,
  output logic [31:0]       c32
);

  logic is_nan;

  always_comb begin
    is_nan = (src[30:23] == 8'hFF) && (src[22:0] != 23'd0);
    c32    = (cls == CLS_FLOAT) ? src : 32'd0;
    case (cls)
      CLS_UNORM: begin
        c8  = cvt_unorm(src, 8)[7:0];
        c16 = cvt_unorm(src, 16);
      end
      CLS_SNORM: begin
        c8  = cvt_snorm(src, 8)[7:0];
        c16 = cvt_snorm(src, 16);
      end
      CLS_UINT: begin
        c8  = sat_uint(src, 8)[7:0];
        c16 = sat_uint(src, 16);
      end
      CLS_SINT: begin
        c8  = sat_sint(src, 8)[7:0];
        c16 = sat_sint(src, 16);
      end
      default: begin
        c8  = 8'd0;
        c16 = 16'd0;
      end
    endcase
  end

  always_comb begin
    if ((cls == CLS_UNORM || cls == CLS_SNORM) && is_nan)
      p_nan_zero_r6: assert (c8 == 8'd0 && c16 == 16'd0);
    if (cls == CLS_UNORM && !src[31] && src[30:23] >= 8'd127 && !is_nan)
      p_unorm_top_r6: assert (c8 == 8'hFF && c16 == 16'hFFFF);
    if (cls == CLS_UINT && src[31:16] == 16'd0)
      p_uint_inrange_r8: assert (c16 == src[15:0]);
  end

endmodule

// File: rtl/sfc_pack.sv
module sfc_pack
  import sfc_pkg::*;
(
  input  logic [NCOMP-1:0][7:0]  c8,
  input  logic [NCOMP-1:0][15:0] c16,
  input  logic [NCOMP-1:0][31:0] c32,
  input  logic [2:0]             wsel,
  input  logic [CNT_W-1:0]       nchan,
  input  logic [CNT_W-1:0]       nsrc,
  input  logic [BYTES_W-1:0]     nbytes,
  output logic [WORD_W-1:0]      data,
  output logic [LANE_W-1:0]      lanes
);

  logic [NCOMP*8-1:0]  d8;
  logic [NCOMP*16-1:0] d16;
  logic [NCOMP*32-1:0] d32;

  for (genvar k = 0; k < NCOMP; k++) begin : g_comp
    logic used;
    assign used = (CNT_W'(k) < nchan) && (CNT_W'(k) < nsrc);
    assign d8[k*8 +: 8]    = used ? c8[k]  : 8'd0;
    assign d16[k*16 +: 16] = used ? c16[k] : 16'd0;
    assign d32[k*32 +: 32] = used ? c32[k] : 32'd0;
  end

  always_comb begin
    case (wsel)
      3'b100:  data = d32;
      3'b010:  data = WORD_W'(d16);
      default: data = WORD_W'(d8);
    endcase
    lanes = LANE_W'(((LANE_W + 1)'(1) << nbytes) - (LANE_W + 1)'(1));
  end

  always_comb begin
    p_lanes_contig_r3: assert ((((LANE_W + 1)'(lanes) + (LANE_W + 1)'(1)) & (LANE_W + 1)'(lanes)) == '0);
    p_lanes_count_r3: assert ($countones(lanes) == int'(nbytes));
  end

endmodule

// File: rtl/sfc_store_packer.sv
module sfc_store_packer
  import sfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_src,
  input  logic [2:0]        in_class,
  input  logic              in_wide,
  input  logic [1:0]        in_chans,
  input  logic [1:0]        in_count,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic [LANE_W-1:0] out_lanes
);

  sfc_class_e            cls;
  logic [2:0]            wsel;
  logic [CNT_W-1:0]      nchan;
  logic [CNT_W-1:0]      nsrc;
  logic [BYTES_W-1:0]    nbytes;
  logic [NCOMP-1:0][7:0]  c8;
  logic [NCOMP-1:0][15:0] c16;
  logic [NCOMP-1:0][31:0] c32;
  logic [WORD_W-1:0]     pk_data;
  logic [LANE_W-1:0]     pk_lanes;

  sfc_decode u_dec (
    .cls_raw   (in_class),
    .wide      (in_wide),
    .chan_code (in_chans),
    .cnt_code  (in_count),
    .cls       (cls),
    .wsel      (wsel),
    .nchan     (nchan),
    .nsrc      (nsrc),
    .nbytes    (nbytes)
  );

  for (genvar i = 0; i < NCOMP; i++) begin : g_lane
    sfc_lane_conv u_conv (
      .src (in_src[i*ELEM_W +: ELEM_W]),
      .cls (cls),
      .c8  (c8[i]),
      .c16 (c16[i]),
      .c32 (c32[i])
    );
  end

  sfc_pack u_pack (
    .c8     (c8),
    .c16    (c16),
    .c32    (c32),
    .wsel   (wsel),
    .nchan  (nchan),
    .nsrc   (nsrc),
    .nbytes (nbytes),
    .data   (pk_data),
    .lanes  (pk_lanes)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_lanes <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data  <= pk_data;
        out_lanes <= pk_lanes;
      end
    end
  end

  p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_hold_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_data) && $stable(out_lanes)));

  for (genvar b = 0; b < LANE_W; b++) begin : g_chk
    p_dead_byte_zero_r4: assert property (@(posedge clk) disable iff (rst)
      !out_lanes[b] |-> (out_data[b*8 +: 8] == 8'd0));
  end

endmodule

// File: tb/sfc_store_packer_test.sv
module sfc_store_packer_test;
  import sfc_pkg::*;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [WORD_W-1:0] in_src = '0;
  logic [2:0]        in_class = '0;
  logic              in_wide = 1'b0;
  logic [1:0]        in_chans = '0;
  logic [1:0]        in_count = '0;
  logic              out_valid;
  logic [WORD_W-1:0] out_data;
  logic [LANE_W-1:0] out_lanes;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sfc_store_packer uut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_src    (in_src),
    .in_class  (in_class),
    .in_wide   (in_wide),
    .in_chans  (in_chans),
    .in_count  (in_count),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_lanes (out_lanes)
  );

  task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Issue one request, then sample the registered result at the next falling edge.
  task automatic run(input logic [2:0] cls, input logic wide, input logic [1:0] ch,
                     input logic [1:0] cnt, input logic [31:0] s0, input logic [31:0] s1,
                     input logic [31:0] s2, input logic [31:0] s3);
    @(negedge clk);
    in_valid = 1'b1;
    in_class = cls;
    in_wide  = wide;
    in_chans = ch;
    in_count = cnt;
    in_src   = {s3, s2, s1, s0};
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_out(input string req, input logic [127:0] d, input logic [15:0] m);
    check({req, " valid"}, 128'(out_valid), 128'd1);
    check({req, " data"}, out_data, d);
    check({req, " lanes"}, 128'(out_lanes), 128'(m));
  endtask

  task automatic t_reset;
    check("R1 reset valid", 128'(out_valid), 128'd0);
    check("R1 reset data", out_data, 128'd0);
    check("R1 reset lanes", 128'(out_lanes), 128'd0);
  endtask

  task automatic t_unorm;
    // 1.0, 0.5 (127.5 -> 128), NaN, -0.5
    run(3'd0, 1'b0, 2'd2, 2'd2, 32'h3F800000, 32'h3F000000, 32'h7FC00000, 32'hBF000000);
    expect_out("R6 unorm8 R2", 128'h000080FF, 16'h000F);
    check("R1 idle after one", 128'(out_valid), 128'd1);
    @(negedge clk);
    check("R1 valid drops", 128'(out_valid), 128'd0);
    // 0.25 -> 16383.75 -> 16384, 2.0 -> clamp
    run(3'd0, 1'b1, 2'd1, 2'd1, 32'h3E800000, 32'h40000000, 32'd0, 32'd0);
    expect_out("R6 unorm16", 128'hFFFF4000, 16'h000F);
    // tiny 0.001 -> 0, +inf -> max
    run(3'd0, 1'b0, 2'd1, 2'd1, 32'h3A83126F, 32'h7F800000, 32'd0, 32'd0);
    expect_out("R6 unorm8 small/inf", 128'h0000FF00, 16'h0003);
  endtask

  task automatic t_snorm;
    // -1.0 -> 0x81, 0.5 -> 63.5 -> 64, -0.5 -> -64, +inf -> 127
    run(3'd1, 1'b0, 2'd2, 2'd2, 32'hBF800000, 32'h3F000000, 32'hBF000000, 32'h7F800000);
    expect_out("R7 snorm8", 128'h7FC04081, 16'h000F);
    // -2.0 clamps to -32767
    run(3'd1, 1'b1, 2'd0, 2'd0, 32'hC0000000, 32'd0, 32'd0, 32'd0);
    expect_out("R7 snorm16", 128'h8001, 16'h0003);
    // NaN -> 0, 0.75*32767 = 24575.25 -> 24575
    run(3'd1, 1'b1, 2'd1, 2'd1, 32'hFFC00001, 32'h3F400000, 32'd0, 32'd0);
    expect_out("R7 snorm16 nan", 128'h5FFF0000, 16'h000F);
  endtask

  task automatic t_uint;
    run(3'd2, 1'b0, 2'd2, 2'd2, 32'd5, 32'd255, 32'd256, 32'hFFFFFFFF);
    expect_out("R8 uint8", 128'hFFFFFF05, 16'h000F);
    // one source into two channels: G zero-filled
    run(3'd2, 1'b1, 2'd1, 2'd0, 32'd70000, 32'd9, 32'd9, 32'd9);
    expect_out("R8 R5 uint16 fill", 128'h0000FFFF, 16'h000F);
  endtask

  task automatic t_sint;
    run(3'd3, 1'b0, 2'd2, 2'd1, 32'hFFFFFF38, 32'd100, 32'd7, 32'd7);
    expect_out("R9 R5 sint8", 128'h00006480, 16'h000F);
    // extra source elements discarded
    run(3'd3, 1'b1, 2'd1, 2'd2, 32'd40000, 32'hFFFFFFFB, 32'd7, 32'd9);
    expect_out("R9 R4 sint16", 128'hFFFB7FFF, 16'h000F);
    run(3'd3, 1'b1, 2'd2, 2'd2, 32'hFFFF63C0, 32'd0, 32'd1, 32'h7FFFFFFF);
    expect_out("R9 R2 sint16x4", 128'h7FFF000100008000, 16'h00FF);
  endtask

  task automatic t_float;
    run(3'd4, 1'b0, 2'd2, 2'd2, 32'h3F800000, 32'h7FC00123, 32'hBF000000, 32'h12345678);
    expect_out("R10 float4", 128'h12345678BF0000007FC001233F800000, 16'hFFFF);
    run(3'd4, 1'b1, 2'd0, 2'd2, 32'hDEADBEEF, 32'h1, 32'h2, 32'h3);
    expect_out("R10 R4 float1", 128'hDEADBEEF, 16'h000F);
    run(3'd4, 1'b0, 2'd1, 2'd0, 32'hCAFEF00D, 32'h1, 32'h2, 32'h3);
    expect_out("R10 R5 float2", 128'hCAFEF00D, 16'h00FF);
  endtask

  task automatic t_discard;
    run(3'd0, 1'b0, 2'd0, 2'd2, 32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h3F800000);
    expect_out("R4 R3 unorm8x1", 128'hFF, 16'h0001);
  endtask

  task automatic t_invalid;
    run(3'd5, 1'b0, 2'd2, 2'd2, 32'd1, 32'd2, 32'd3, 32'd4);
    expect_out("R11 bad class", 128'd0, 16'h0000);
    run(3'd2, 1'b0, 2'd3, 2'd2, 32'd1, 32'd2, 32'd3, 32'd4);
    expect_out("R11 bad chans", 128'd0, 16'h0000);
    run(3'd2, 1'b0, 2'd2, 2'd3, 32'd1, 32'd2, 32'd3, 32'd4);
    expect_out("R11 bad count", 128'd0, 16'h0000);
  endtask

  task automatic t_hold;
    run(3'd2, 1'b0, 2'd2, 2'd2, 32'd1, 32'd2, 32'd3, 32'd4);
    expect_out("R12 setup", 128'h04030201, 16'h000F);
    in_src   = {4{32'hFFFFFFFF}};
    in_class = 3'd4;
    in_chans = 2'd2;
    repeat (3) @(negedge clk);
    check("R12 hold data", out_data, 128'h04030201);
    check("R12 hold lanes", 128'(out_lanes), 128'h000F);
    check("R12 R1 idle valid", 128'(out_valid), 128'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst = 1'b0;
    t_unorm;
    t_snorm;
    t_uint;
    t_sint;
    t_float;
    t_discard;
    t_invalid;
    t_hold;
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog got=timeout exp=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule